// File: doc/BRIEF.md
# ADC Result Compare Gate

This block sits after a converter's correction stage and decides, for every finished conversion result, whether that result is delivered to the rest of the chip. Each result arrives with a one-cycle valid strobe, along with two programmable thresholds and three mode bits: a compare enable, a greater flag and a range flag. A result that passes the selected test is written to the output register and announced with a one-cycle completion strobe. A result that fails is dropped silently. The output register keeps the last accepted value, and no completion is raised for a dropped result.

With the range flag clear, the block tests one threshold. The greater flag chooses between "below threshold A" and "at or above threshold A". With the range flag set, the two thresholds form a window. When threshold A is not above threshold B, the result must lie inside the window. When A is above B, the result must lie outside the span from B to A. In range tests the greater flag makes the bounds inclusive, and clearing it makes them exclusive. With the compare enable clear, every result is accepted.

The control is a two-state machine. In `ST_IDLE` it waits for a result. The transition `take` (valid high) captures the result, the thresholds and the decoded test, and moves to `ST_JUDGE`. In `ST_JUDGE` the captured result is tested and the verdict is registered onto the outputs. From `ST_JUDGE`, transition `again` (valid high) captures a new result and stays in `ST_JUDGE`, so results can arrive back to back. Transition `rest` (valid low) returns to `ST_IDLE`.

Top module: `adc_cmp_gate`

## Requirements
- R1: After reset, `acc_done` is 0 and `acc_data` is 0.
- R2: With `cmp_on` = 0, every result is accepted, whatever the thresholds and other mode bits.
- R3: With `cmp_on` = 1, `cmp_ge` = 0 and `cmp_win` = 0, a result is accepted only when it is strictly less than `thr_a`.
- R4: With `cmp_on` = 1, `cmp_ge` = 1 and `cmp_win` = 0, a result is accepted only when it is greater than or equal to `thr_a`.
- R5: With `cmp_on` = 1, `cmp_win` = 1, `cmp_ge` = 1 and `thr_a` <= `thr_b`, a result is accepted only when `thr_a` <= result <= `thr_b`.
- R6: With `cmp_on` = 1, `cmp_win` = 1, `cmp_ge` = 0 and `thr_a` <= `thr_b`, a result is accepted only when `thr_a` < result < `thr_b`.
- R7: With `cmp_on` = 1, `cmp_win` = 1, `cmp_ge` = 1 and `thr_a` > `thr_b`, a result is accepted only when result <= `thr_b` or result >= `thr_a`.
- R8: With `cmp_on` = 1, `cmp_win` = 1, `cmp_ge` = 0 and `thr_a` > `thr_b`, a result is accepted only when result < `thr_b` or result > `thr_a`.
- R9: A rejected result raises no `acc_done`, and `acc_data` keeps its previous value.
- R10: An accepted result sampled at clock edge k appears on `acc_data`, with `acc_done` high for exactly one cycle, after edge k+1. Results on consecutive cycles are each accepted or rejected on their own.
- R11: The thresholds and mode bits are sampled at the same edge as the result. Changing them afterwards does not alter the verdict on that result.
- R12: All comparisons are unsigned across the full `DATA_W` (default 16) bits of the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | One-cycle strobe marking a new result |
| res_data | input | DATA_W | Corrected conversion result |
| thr_a | input | DATA_W | First compare value |
| thr_b | input | DATA_W | Second compare value |
| cmp_on | input | 1 | Compare enable; 0 accepts everything |
| cmp_ge | input | 1 | Greater flag: direction / bound inclusiveness |
| cmp_win | input | 1 | Range flag: window test instead of single threshold |
| acc_data | output | DATA_W | Last accepted result |
| acc_done | output | 1 | One-cycle completion strobe for an accepted result |

## Verification
Each of the seven test kinds is tried with results placed exactly on the bounds, one step inside them and one step outside them. This distinguishes strict bounds from inclusive ones and inside tests from outside tests. Equal thresholds in window mode check that the A <= B choice selects the inside test, and that the greater flag alone decides whether the single point passes. Values near the top of the 16-bit range catch comparisons that are truncated or signed. Further directed cases cover reset, threshold changes right after sampling, and back-to-back results with mixed verdicts.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;

    // Test kind picked from the mode bits and threshold order
    typedef enum logic [2:0] {
        TEST_ALL      = 3'd0,
        TEST_LT       = 3'd1,
        TEST_GE       = 3'd2,
        TEST_IN_INCL  = 3'd3,
        TEST_IN_EXCL  = 3'd4,
        TEST_OUT_INCL = 3'd5,
        TEST_OUT_EXCL = 3'd6
    } test_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_JUDGE = 1'b1
    } state_t;

endpackage

// File: rtl/cmpu_mode_dec.sv
module cmpu_mode_dec
    import cmpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              cmp_on,
    input  logic              cmp_ge,
    input  logic              cmp_win,
    input  logic [DATA_W-1:0] thr_a,
    input  logic [DATA_W-1:0] thr_b,
    output test_t             test
);

    logic inside_sel;

    // A not above B forms a window; A above B forms a gap
    assign inside_sel = (thr_a <= thr_b);

    always_comb begin
        if (!cmp_on) begin
            test = TEST_ALL;
        end else if (!cmp_win) begin
            test = cmp_ge ? TEST_GE : TEST_LT;
        end else if (inside_sel) begin
            test = cmp_ge ? TEST_IN_INCL : TEST_IN_EXCL;
        end else begin
            test = cmp_ge ? TEST_OUT_INCL : TEST_OUT_EXCL;
        end
    end

endmodule

// File: rtl/cmpu_judge.sv
module cmpu_judge
    import cmpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  test_t             test,
    input  logic [DATA_W-1:0] val,
    input  logic [DATA_W-1:0] lim_a,
    input  logic [DATA_W-1:0] lim_b,
    output logic              pass
);

    always_comb begin
        unique case (test)
            TEST_ALL:      pass = 1'b1;
            TEST_LT:       pass = (val <  lim_a);
            TEST_GE:       pass = (val >= lim_a);
            TEST_IN_INCL:  pass = (val >= lim_a) && (val <= lim_b);
            TEST_IN_EXCL:  pass = (val >  lim_a) && (val <  lim_b);
            TEST_OUT_INCL: pass = (val <= lim_b) || (val >= lim_a);
            TEST_OUT_EXCL: pass = (val <  lim_b) || (val >  lim_a);
            default:       pass = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmpu_seq.sv
module cmpu_seq
    import cmpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] thr_a,
    input  logic [DATA_W-1:0] thr_b,
    input  test_t             test_in,
    input  logic              verdict,
    output test_t             cap_test,
    output logic [DATA_W-1:0] cap_val,
    output logic [DATA_W-1:0] cap_a,
    output logic [DATA_W-1:0] cap_b,
    output logic [DATA_W-1:0] acc_data,
    output logic              acc_done
);

    state_t state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: take, again, rest
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (res_valid) state_nx = ST_JUDGE;
            ST_JUDGE: state_nx = res_valid ? ST_JUDGE : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Capture result and its configuration together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_test <= TEST_ALL;
            cap_val  <= '0;
            cap_a    <= '0;
            cap_b    <= '0;
        end else if (res_valid) begin
            cap_test <= test_in;
            cap_val  <= res_data;
            cap_a    <= thr_a;
            cap_b    <= thr_b;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_done <= 1'b0;
            acc_data <= '0;
        end else begin
            acc_done <= 1'b0;
            unique case (state)
                ST_IDLE: ;
                ST_JUDGE: begin
                    if (verdict) begin
                        acc_done <= 1'b1;
                        acc_data <= cap_val;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10: a completion always follows a sampled result
    p_done_after_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> $past(res_valid, 2));

    // R9: output register moves only with a completion
    p_hold_on_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_done |-> $stable(acc_data));

    // R2: compare disabled always leads to a completion
    p_all_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JUDGE && cap_test == TEST_ALL) |=> acc_done);

    // R3: accepted below-threshold result is below threshold
    p_lt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JUDGE && cap_test == TEST_LT && verdict) |-> (cap_val < cap_a));

    // R5: accepted inclusive-window result lies in the window
    p_in_incl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JUDGE && cap_test == TEST_IN_INCL && verdict)
            |-> (cap_val >= cap_a && cap_val <= cap_b));

    // R10: accepted data matches the result sampled two edges earlier
    p_data_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> (acc_data == $past(res_data, 2)));

endmodule

// File: rtl/adc_cmp_gate.sv
module adc_cmp_gate
    import cmpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] thr_a,
    input  logic [DATA_W-1:0] thr_b,
    input  logic              cmp_on,
    input  logic              cmp_ge,
    input  logic              cmp_win,
    output logic [DATA_W-1:0] acc_data,
    output logic              acc_done
);

    test_t             live_test;
    test_t             cap_test;
    logic [DATA_W-1:0] cap_val;
    logic [DATA_W-1:0] cap_a;
    logic [DATA_W-1:0] cap_b;
    logic              verdict;

    cmpu_mode_dec #(.DATA_W(DATA_W)) u_dec (
        .cmp_on  (cmp_on),
        .cmp_ge  (cmp_ge),
        .cmp_win (cmp_win),
        .thr_a   (thr_a),
        .thr_b   (thr_b),
        .test    (live_test)
    );

    cmpu_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .thr_a     (thr_a),
        .thr_b     (thr_b),
        .test_in   (live_test),
        .verdict   (verdict),
        .cap_test  (cap_test),
        .cap_val   (cap_val),
        .cap_a     (cap_a),
        .cap_b     (cap_b),
        .acc_data  (acc_data),
        .acc_done  (acc_done)
    );

    cmpu_judge #(.DATA_W(DATA_W)) u_judge (
        .test  (cap_test),
        .val   (cap_val),
        .lim_a (cap_a),
        .lim_b (cap_b),
        .pass  (verdict)
    );

endmodule

// File: tb/adc_cmp_gate_test.sv
module adc_cmp_gate_test;

    localparam int W = 16;
    // Vector: {req[3:0], on, ge, win, thr_a, thr_b, res, pass}
    localparam int VW = 4 + 3 + 3*W + 1;
    localparam int NV = 33;

    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd2,  3'b000, 16'd100,   16'd0,     16'd500,   1'b1}, // R2
        {4'd2,  3'b011, 16'd10,    16'd20,    16'd900,   1'b1}, // R2
        {4'd3,  3'b100, 16'd100,   16'd0,     16'd99,    1'b1}, // R3
        {4'd3,  3'b100, 16'd100,   16'd0,     16'd100,   1'b0}, // R3
        {4'd3,  3'b100, 16'd100,   16'd0,     16'd0,     1'b1}, // R3
        {4'd4,  3'b110, 16'd100,   16'd0,     16'd100,   1'b1}, // R4
        {4'd4,  3'b110, 16'd100,   16'd0,     16'd99,    1'b0}, // R4
        {4'd5,  3'b111, 16'd10,    16'd20,    16'd10,    1'b1}, // R5
        {4'd5,  3'b111, 16'd10,    16'd20,    16'd20,    1'b1}, // R5
        {4'd5,  3'b111, 16'd10,    16'd20,    16'd21,    1'b0}, // R5
        {4'd5,  3'b111, 16'd10,    16'd20,    16'd9,     1'b0}, // R5
        {4'd5,  3'b111, 16'd50,    16'd50,    16'd50,    1'b1}, // R5
        {4'd6,  3'b101, 16'd10,    16'd20,    16'd10,    1'b0}, // R6
        {4'd6,  3'b101, 16'd10,    16'd20,    16'd11,    1'b1}, // R6
        {4'd6,  3'b101, 16'd10,    16'd20,    16'd19,    1'b1}, // R6
        {4'd6,  3'b101, 16'd10,    16'd20,    16'd20,    1'b0}, // R6
        {4'd6,  3'b101, 16'd50,    16'd50,    16'd50,    1'b0}, // R6
        {4'd7,  3'b111, 16'd20,    16'd10,    16'd10,    1'b1}, // R7
        {4'd7,  3'b111, 16'd20,    16'd10,    16'd20,    1'b1}, // R7
        {4'd7,  3'b111, 16'd20,    16'd10,    16'd15,    1'b0}, // R7
        {4'd7,  3'b111, 16'd20,    16'd10,    16'd11,    1'b0}, // R7
        {4'd8,  3'b101, 16'd20,    16'd10,    16'd10,    1'b0}, // R8
        {4'd8,  3'b101, 16'd20,    16'd10,    16'd20,    1'b0}, // R8
        {4'd8,  3'b101, 16'd20,    16'd10,    16'd9,     1'b1}, // R8
        {4'd8,  3'b101, 16'd20,    16'd10,    16'd21,    1'b1}, // R8
        {4'd8,  3'b101, 16'd20,    16'd10,    16'd15,    1'b0}, // R8
        {4'd12, 3'b110, 16'h8000,  16'd0,     16'hFFFF,  1'b1}, // R12
        {4'd12, 3'b100, 16'h8000,  16'd0,     16'h7FFF,  1'b1}, // R12
        {4'd12, 3'b100, 16'h8000,  16'd0,     16'h8001,  1'b0}, // R12
        {4'd12, 3'b100, 16'hFFFF,  16'd0,     16'hFFFF,  1'b0}, // R12
        {4'd12, 3'b111, 16'h0001,  16'hFFFE,  16'hFFFF,  1'b0}, // R12
        {4'd12, 3'b111, 16'hFFFF,  16'h0000,  16'hFFFF,  1'b1}, // R12
        {4'd9,  3'b110, 16'hF000,  16'd0,     16'h0123,  1'b0}  // R9
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         res_valid = 1'b0;
    logic [W-1:0] res_data = '0;
    logic [W-1:0] thr_a = '0;
    logic [W-1:0] thr_b = '0;
    logic         cmp_on = 1'b0;
    logic         cmp_ge = 1'b0;
    logic         cmp_win = 1'b0;
    logic [W-1:0] acc_data;
    logic         acc_done;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] model_out = '0;

    always #4 clk = ~clk;

    adc_cmp_gate #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .thr_a(thr_a), .thr_b(thr_b), .cmp_on(cmp_on), .cmp_ge(cmp_ge),
        .cmp_win(cmp_win), .acc_data(acc_data), .acc_done(acc_done)
    );

    task automatic check(input string tag, input logic done_exp, input logic [W-1:0] data_exp);
        n_chk++;
        if (acc_done !== done_exp || acc_data !== data_exp) begin
            n_bad++;
            $display("FAIL %s: done=%0b data=%h expected done=%0b data=%h",
                     tag, acc_done, acc_data, done_exp, data_exp);
        end
    endtask

    task automatic drive(input logic [2:0] mode, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] r);
        {cmp_on, cmp_ge, cmp_win} = mode;
        thr_a = a; thr_b = b; res_data = r; res_valid = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1 reset", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 1'b0, '0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string tag;
            v = VEC[i];
            drive(v[VW-5 -: 3], v[3*W -: W], v[2*W -: W], v[W -: W]);
            @(negedge clk);
            res_valid = 1'b0;
            @(negedge clk);
            if (v[0]) model_out = v[W -: W];
            tag = $sformatf("R%0d vec %0d", v[VW-1 -: 4], i);
            check(tag, v[0], model_out);
        end

        // R9: rejected result leaves data and strobe idle on the next cycle too
        drive(3'b100, 16'd5, 16'd0, 16'd700);
        @(negedge clk); res_valid = 1'b0;
        @(negedge clk); check("R9 reject", 1'b0, model_out);
        @(negedge clk); check("R9 reject hold", 1'b0, model_out);

        // R11: thresholds changed right after sampling
        drive(3'b100, 16'd1000, 16'd0, 16'd300);
        @(negedge clk);
        res_valid = 1'b0; thr_a = 16'd1; cmp_ge = 1'b1; cmp_win = 1'b1;
        @(negedge clk); model_out = 16'd300;
        check("R11 late change", 1'b1, model_out);

        // R10: back to back, pass / fail / pass
        drive(3'b110, 16'd100, 16'd0, 16'd150);
        @(negedge clk); res_data = 16'd50;
        @(negedge clk); res_data = 16'd222;
        check("R10 b2b first", 1'b1, 16'd150);
        @(negedge clk); res_valid = 1'b0;
        check("R10 b2b reject", 1'b0, 16'd150);
        @(negedge clk);
        check("R10 b2b third", 1'b1, 16'd222);
        @(negedge clk);
        check("R10 single pulse", 1'b0, 16'd222);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", 1'b0, '0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule